// File: doc/BRIEF.md
# Serial Pattern Progress Tracker

This block watches a one-bit serial stream, taking one bit at every rising clock edge, and follows how much of the fixed five-bit pattern 0, 0, 1, 0, 1 has arrived. The first bit listed is the first to arrive. A five-bit one-hot output reports the depth of the current partial match. Bit k-1 is high when the last k bits received equal the first k pattern bits. The output is all zero when no prefix is matched. When the whole pattern has arrived, the top output bit is high.

The tracker is a Moore machine. The output register is the state register, so the output changes only at a clock edge and never depends on the current input. When a bit breaks a partial match, the tracker falls back to the longest pattern prefix that still ends the received stream, so overlapping occurrences are not lost. A synchronous clear input puts the tracker back to idle. An active-low asynchronous reset puts it there at power-on.

Top module: `pattern_progress_det`

## Requirements
- R1: While rst_ni is low, progress_o is 5'b00000 with no clock edge needed.
- R2: With clear_i low, progress_o takes the value 1 << (k-1) after the edge where k is the largest value (0 to 5) such that the last k sampled bits equal the first k bits of the pattern 0,0,1,0,1 (first arrival first). If k is 0, progress_o is 5'b00000. A complete pattern gives 5'b10000.
- R3: A rising edge with clear_i high gives progress_o = 5'b00000, whatever bit_i is.
- R4: At most one bit of progress_o is high in every cycle.
- R5: From 5'b00001 or 5'b00100, an edge with bit_i = 1 gives 5'b00000. From 5'b00000, bit_i = 1 leaves it at 5'b00000.
- R6: From 5'b00010, an edge with bit_i = 0 leaves progress_o at 5'b00010.
- R7: From 5'b01000, an edge with bit_i = 0 gives 5'b00010.
- R8: From 5'b10000, an edge with bit_i = 0 gives 5'b00001, and an edge with bit_i = 1 gives 5'b00000.
- R9: progress_o changes only at a rising clock edge (or at reset). A change of bit_i or clear_i between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; bit_i and clear_i are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to idle |
| clear_i | input | 1 | Synchronous return to idle; has priority over bit_i |
| bit_i | input | 1 | Serial data bit |
| progress_o | output | 5 | One-hot partial-match depth; all zero when idle |

## Verification
The assertions assume that bit_i and clear_i hold known values at every rising edge and that reset is held long enough to settle. The bench drives both inputs only at falling edges, so this always holds. The properties check only the next state after each edge, so they rely on an input held for a single edge being the whole stimulus for that transition. The random stimulus includes occasional clears and a mix of bit values, which brings the tracker into every level and every fallback arc.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int PAT_LEN = 5;
  // bit i is the i-th arriving pattern bit
  localparam logic [PAT_LEN-1:0] PAT_SEQ = 5'b10100;
  localparam int NLVL = PAT_LEN + 1;

  // longest pattern prefix ending the stream "prefix(lvl) followed by b"
  function automatic int follow(int lvl, logic b);
    logic [PAT_LEN:0] seq;
    int n;
    int res;
    logic hit;
    seq = '0;
    res = 0;
    for (int i = 0; i < PAT_LEN; i++)
      if (i < lvl) seq[i] = PAT_SEQ[i];
    seq[lvl] = b;
    n = lvl + 1;
    for (int j = 1; j <= PAT_LEN; j++) begin
      if (j <= n) begin
        hit = 1'b1;
        for (int i = 0; i < PAT_LEN; i++)
          if (i < j && seq[n-j+i] != PAT_SEQ[i]) hit = 1'b0;
        if (hit) res = j;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pd_next_level.sv
module pd_next_level
  import pd_pkg::*;
(
  input  logic [PAT_LEN-1:0] state_i,
  input  logic               bit_i,
  output logic [PAT_LEN-1:0] next_o
);
  logic [NLVL-1:0] lvl;
  assign lvl = {state_i, ~|state_i};

  for (genvar t = 1; t < NLVL; t++) begin : g_tgt
    logic [NLVL-1:0] src;
    for (genvar k = 0; k < NLVL; k++) begin : g_src
      localparam int T0 = follow(k, 1'b0);
      localparam int T1 = follow(k, 1'b1);
      localparam logic HIT0 = (T0 == t);
      localparam logic HIT1 = (T1 == t);
      assign src[k] = lvl[k] & (bit_i ? HIT1 : HIT0);
    end
    assign next_o[t-1] = |src;
  end
endmodule

// File: rtl/pd_state_reg.sv
module pd_state_reg
  import pd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [PAT_LEN-1:0] next_i,
  output logic [PAT_LEN-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= '0;
    else if (clear_i) state_o <= '0;
    else              state_o <= next_i;
  end
endmodule

// File: rtl/pattern_progress_det.sv
module pattern_progress_det
  import pd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               bit_i,
  output logic [PAT_LEN-1:0] progress_o
);
  logic [PAT_LEN-1:0] state_q;
  logic [PAT_LEN-1:0] state_d;

  pd_next_level u_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .next_o  (state_d)
  );

  pd_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .next_i  (state_d),
    .state_o (state_q)
  );

  assign progress_o = state_q;
endmodule

// File: rtl/pd_checker.sv
module pd_checker
  import pd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               bit_i,
  input logic [PAT_LEN-1:0] progress_o
);
  a_r4_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(progress_o));

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> progress_o == '0);

  a_r2_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == '0 && !bit_i) |=> progress_o == 5'b00001);

  a_r2_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == 5'b01000 && bit_i) |=> progress_o == 5'b10000);

  a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (progress_o == 5'b00001 || progress_o == 5'b00100) && bit_i)
      |=> progress_o == '0);

  a_r6_hold_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == 5'b00010 && !bit_i) |=> progress_o == 5'b00010);

  a_r7_back_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == 5'b01000 && !bit_i) |=> progress_o == 5'b00010);

  a_r8_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == 5'b10000 && !bit_i) |=> progress_o == 5'b00001);

  a_r8_after_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && progress_o == 5'b10000 && bit_i) |=> progress_o == '0);
endmodule

bind pattern_progress_det pd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .bit_i      (bit_i),
  .progress_o (progress_o)
);

// File: tb/tb_pattern_progress_det.sv
`timescale 1ns/1ps
module tb_pattern_progress_det;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [4:0] progress_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model: recent bits (newest at [0]) and bits since idle
  logic [4:0] hist = '0;
  int cnt = 0;
  logic [4:0] exp_q = '0;
  localparam logic PAT [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  always #5 clk_i = ~clk_i;

  pattern_progress_det dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .bit_i(bit_i), .progress_o(progress_o)
  );

  function automatic logic [4:0] depth_code(logic [4:0] h, int c);
    int best = 0;
    for (int j = 1; j <= 5; j++) begin
      bit ok = (j <= c);
      for (int i = 0; i < 5; i++)
        if (i < j && h[j-1-i] != PAT[i]) ok = 0;
      if (ok) best = j;
    end
    return (best == 0) ? 5'b00000 : 5'(1 << (best - 1));
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: progress_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic b, logic c, string tag, bit mid = 0);
    bit_i = b;
    clear_i = c;
    if (mid) begin
      #2 bit_i = ~b; clear_i = ~c;
      #1 check("R9", progress_o, exp_q);
      bit_i = b; clear_i = c;
    end
    @(posedge clk_i);
    if (c) begin
      hist = '0; cnt = 0;
    end else begin
      hist = {hist[3:0], b};
      if (cnt < 5) cnt++;
      else cnt = 5;
    end
    exp_q = depth_code(hist, cnt);
    @(negedge clk_i);
    check(tag, progress_o, exp_q);
  endtask

  task automatic seq(logic [4:0] bits, int n, string tag);
    for (int i = 0; i < n; i++) step(bits[i], 1'b0, tag);
  endtask

  initial begin
    #2 check("R1", progress_o, 5'b00000);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 full walk, R9 mid-cycle input changes
    step(0, 0, "R2", 1); check("R2", progress_o, 5'b00001);
    step(0, 0, "R2", 1); check("R2", progress_o, 5'b00010);
    step(1, 0, "R2");    check("R2", progress_o, 5'b00100);
    step(0, 0, "R2");    check("R2", progress_o, 5'b01000);
    step(1, 0, "R2", 1); check("R2", progress_o, 5'b10000);
    // R8 overlap after match
    step(0, 0, "R8");    check("R8", progress_o, 5'b00001);
    seq(5'b10100 >> 1, 4, "R2"); check("R2", progress_o, 5'b10000);
    step(1, 0, "R8");    check("R8", progress_o, 5'b00000);
    // R5 one at idle, level 1, level 3
    step(1, 0, "R5");    check("R5", progress_o, 5'b00000);
    step(0, 0, "R5");
    step(1, 0, "R5");    check("R5", progress_o, 5'b00000);
    seq(5'b00100, 3, "R5");
    step(1, 0, "R5");    check("R5", progress_o, 5'b00000);
    // R6 run of zeros
    seq(5'b00000, 4, "R6"); check("R6", progress_o, 5'b00010);
    // R7 zero at level 4
    seq(5'b00100, 4, "R7");
    step(0, 0, "R7");    check("R7", progress_o, 5'b00010);
    // R3 clear wins over a completing bit
    seq(5'b00100, 4, "R3");
    step(1, 1, "R3");    check("R3", progress_o, 5'b00000);
    step(0, 1, "R3");    check("R3", progress_o, 5'b00000);
    // R1 asynchronous reset mid-cycle
    seq(5'b00100, 3, "R1");
    #2 rst_ni = 1'b0;
    #1 check("R1", progress_o, 5'b00000);
    @(negedge clk_i);
    rst_ni = 1'b1; hist = '0; cnt = 0; exp_q = '0;
    // random mix, R2 and R4
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic rb = ($urandom_range(0, 99) < 45);
      logic rc = ($urandom_range(0, 15) == 0);
      step(rb, rc, "R2");
      checks++;
      if (!$onehot0(progress_o)) begin
        errors++;
        $display("FAIL R4: progress_o=%b expected=at most one bit set", progress_o);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule